// File: doc/BRIEF.md
# Picture Frame Border Generator

This block sits in a display pixel pipeline and lays a solid-colour border over the video. Pixels are counted from the horizontal sync strobe and lines from the vertical and horizontal sync strobes. Each pixel position is compared against a programmable picture window. Pixels outside the window get a fixed border colour on each of the three colour channels. Pixels inside the window keep the incoming colour unchanged.

Each channel's border amplitude is a programmed base value multiplied by a scaled contrast code. The product is clamped to the 8-bit output range. The block also takes part in overlay arbitration. While it inserts border pixels, it reports a programmable 3-bit priority identifier. Software can withdraw the block from arbitration with an enable bit.

All settings are loaded through a simple synchronous register write port. Output colour and priority are registered.

Top module: `pframe_gen`

## Requirements
- R1: After a synchronous active-low reset, the settings are:
  - priority identifier 7, arbitration enabled;
  - horizontal begin 0, vertical start 0, vertical end 57;
  - contrast codes 8, base values 0.
  
  While reset is low, `pix_o` and `prio_o` read 0. After reset, video passes through unchanged with priority 0.
- R2: `pix_o` and `prio_o` are registered. They reflect the input pixel presented one clock earlier, and a new input does not change them before the next rising edge.
- R3: The pixel counter is cleared by `hsync_i`. The pixel presented in the cycle after the strobe is pixel 0. For a horizontal begin B (B neither 0 nor 0x7FF) and end E, pixel h is a border pixel when h < B or h > E.
- R4: A horizontal begin of 0 produces no horizontal border. A horizontal begin of 0x7FF makes every pixel of every line a border pixel, whatever the end value.
- R5: `vsync_i` clears the line counter to 0. Each `hsync_i` without `vsync_i` increments it. For a vertical start S ≠ 0 and end V, line n is a border line when n < S+128 or n > V+128. A vertical start of 0 produces no vertical border.
- R6: Each channel's border amplitude is base × (code + 4), clamped to 255.
- R7: Contrast codes 14 and 15 are invalid. They produce the same amplitude as code 13.
- R8: With the enable bit set, a border pixel outputs the border colour and the priority identifier on `prio_o`. A window pixel passes through with priority 0. With the enable bit clear, every pixel passes through and `prio_o` is 0.
- R9: Register map, data in `wr_data_i`:
  - address 0: horizontal begin in bits [10:0];
  - address 1: horizontal end in bits [10:0];
  - address 2: vertical start in bits [8:0];
  - address 3: vertical end in bits [8:0];
  - addresses 4, 5, 6: channels 0, 1, 2, with base in bits [7:0] and contrast code in bits [11:8];
  - address 7: priority identifier in bits [2:0] and enable in bit 8.
  
  Channel c occupies bits [8c+7:8c] of the pixel buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_i | input | 1 | Line start strobe, one cycle |
| vsync_i | input | 1 | Frame start strobe, one cycle |
| pix_i | input | 24 | Input pixel, three 8-bit channels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| pix_o | output | 24 | Output pixel, registered |
| prio_o | output | 3 | Overlay priority of the output pixel, 0 when not inserting |

## Verification
The bench builds the block with its default parameters:
- 11-bit pixel counter, 10-bit line counter with 9-bit vertical registers and the 128-line offset;
- 8-bit channels with 4-bit contrast codes.

With these values the full-line code 0x7FF and the offset window edges at lines 128 to 131 can be reached in a short run. Every contrast code class can be exercised, including the two invalid codes. The saturation point can be hit with base values that land exactly on 255 and just past it.

// File: rtl/pframe_pkg.sv
`timescale 1ns/1ps
// pframe_pkg: shared widths and the register address map of the picture
// frame border generator. Assumes a 3-bit register address space.
package pframe_pkg;
    localparam int HPOS_W_D  = 11;
    localparam int LINE_W_D  = 10;
    localparam int VREG_W_D  = 9;
    localparam int VOFS_D    = 128;
    localparam int COL_W_D   = 8;
    localparam int CODE_W_D  = 4;
    localparam int ID_W_D    = 3;
    localparam int NCH_D     = 3;
    localparam int DATA_W_D  = 16;
    localparam int ADDR_W_D  = 3;

    typedef enum logic [ADDR_W_D-1:0] {
        REG_HBEG  = 3'd0,
        REG_HEND  = 3'd1,
        REG_VBEG  = 3'd2,
        REG_VEND  = 3'd3,
        REG_COL0  = 3'd4,
        REG_COL1  = 3'd5,
        REG_COL2  = 3'd6,
        REG_PRIO  = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/pframe_regs.sv
`timescale 1ns/1ps
// pframe_regs: settings store of the border generator.
// Holds window limits, per-channel base/contrast and the priority setup.
// Assumes single-cycle writes; a written value takes effect on the next cycle.
module pframe_regs
    import pframe_pkg::*;
#(
    parameter int HPOS_W = HPOS_W_D,
    parameter int VREG_W = VREG_W_D,
    parameter int COL_W  = COL_W_D,
    parameter int CODE_W = CODE_W_D,
    parameter int ID_W   = ID_W_D,
    parameter int NCH    = NCH_D,
    parameter int DATA_W = DATA_W_D,
    parameter int ADDR_W = ADDR_W_D
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             wr_addr_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    output logic [HPOS_W-1:0]             hbeg_o,
    output logic [HPOS_W-1:0]             hend_o,
    output logic [VREG_W-1:0]             vbeg_o,
    output logic [VREG_W-1:0]             vend_o,
    output logic [NCH-1:0][COL_W-1:0]     base_o,
    output logic [NCH-1:0][CODE_W-1:0]    code_o,
    output logic [ID_W-1:0]               id_o,
    output logic                          en_o
);
    localparam int EN_BIT     = 8;
    localparam int VEND_RST   = 57;
    localparam int CODE_RST   = 8;
    localparam int COL_ADDR0  = 4;

    // Upper data bits are not decoded by any register.
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data_i[DATA_W-1:COL_W+CODE_W]};

    // Window and priority registers: reset defaults, then addressed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hbeg_o <= '0;
            hend_o <= '0;
            vbeg_o <= '0;
            vend_o <= VREG_W'(VEND_RST);
            id_o   <= '1;
            en_o   <= 1'b1;
        end else if (wr_en_i) begin
            case (reg_addr_e'(wr_addr_i))
                REG_HBEG: hbeg_o <= wr_data_i[HPOS_W-1:0];
                REG_HEND: hend_o <= wr_data_i[HPOS_W-1:0];
                REG_VBEG: vbeg_o <= wr_data_i[VREG_W-1:0];
                REG_VEND: vend_o <= wr_data_i[VREG_W-1:0];
                REG_PRIO: begin
                    id_o <= wr_data_i[ID_W-1:0];
                    en_o <= wr_data_i[EN_BIT];
                end
                default: ;
            endcase
        end
    end

    // One colour register per channel, placed at consecutive addresses.
    for (genvar c = 0; c < NCH; c++) begin : g_col
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[c] <= '0;
                code_o[c] <= CODE_W'(CODE_RST);
            end else if (wr_en_i && (wr_addr_i == ADDR_W'(COL_ADDR0 + c))) begin
                base_o[c] <= wr_data_i[COL_W-1:0];
                code_o[c] <= wr_data_i[COL_W+CODE_W-1:COL_W];
            end
        end
    end
endmodule

// File: rtl/pframe_raster.sv
`timescale 1ns/1ps
// pframe_raster: pixel and line counters plus the border decision.
// The pixel counter clears on hsync, the line counter clears on vsync and
// advances on every other hsync; both saturate. border_o is combinational
// from the counters and settings for the pixel presented this cycle.
module pframe_raster #(
    parameter int HPOS_W = pframe_pkg::HPOS_W_D,
    parameter int LINE_W = pframe_pkg::LINE_W_D,
    parameter int VREG_W = pframe_pkg::VREG_W_D,
    parameter int VOFS   = pframe_pkg::VOFS_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic [HPOS_W-1:0] hbeg_i,
    input  logic [HPOS_W-1:0] hend_i,
    input  logic [VREG_W-1:0] vbeg_i,
    input  logic [VREG_W-1:0] vend_i,
    output logic              border_o
);
    logic [HPOS_W-1:0] hcnt;
    logic [LINE_W-1:0] vcnt;
    logic [LINE_W-1:0] vtop, vbot;
    logic              h_full, h_off, h_out, v_out;

    // Pixel counter: restart on hsync, otherwise count up and hold at max.
    always_ff @(posedge clk) begin
        if (!rst_n)              hcnt <= '0;
        else if (hsync_i)        hcnt <= '0;
        else if (hcnt != '1)     hcnt <= hcnt + 1'b1;
    end

    // Line counter: restart on vsync, advance per hsync, hold at max.
    always_ff @(posedge clk) begin
        if (!rst_n)                          vcnt <= '0;
        else if (vsync_i)                    vcnt <= '0;
        else if (hsync_i && (vcnt != '1))    vcnt <= vcnt + 1'b1;
    end

    // Border decision for the current pixel position.
    always_comb begin
        h_full   = (hbeg_i == '1);
        h_off    = (hbeg_i == '0);
        h_out    = h_full | (!h_off & ((hcnt < hbeg_i) | (hcnt > hend_i)));
        vtop     = LINE_W'(vbeg_i) + LINE_W'(VOFS);
        vbot     = LINE_W'(vend_i) + LINE_W'(VOFS);
        v_out    = (vbeg_i != '0) & ((vcnt < vtop) | (vcnt > vbot));
        border_o = h_out | v_out;
    end

    assert_hsync_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_i |=> (hcnt == '0));
    assert_vsync_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_i |=> (vcnt == '0));
    assert_line_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_i && !vsync_i && vcnt != '1) |=> (vcnt == $past(vcnt) + 1'b1));
endmodule

// File: rtl/pframe_amp.sv
`timescale 1ns/1ps
// pframe_amp: border amplitude of one channel, base * (code + 4), with
// invalid codes above 13 folded to 13 and the product clamped to full scale.
// Purely combinational.
module pframe_amp #(
    parameter int COL_W    = pframe_pkg::COL_W_D,
    parameter int CODE_W   = pframe_pkg::CODE_W_D,
    parameter int MAX_CODE = 13,
    parameter int CODE_OFS = 4
) (
    input  logic [COL_W-1:0]  base_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [COL_W-1:0]  amp_o
);
    localparam int PROD_W = COL_W + CODE_W + 1;

    logic [CODE_W-1:0] code_eff;
    logic [PROD_W-1:0] factor, prod;

    // Fold invalid codes, scale, and clamp.
    always_comb begin
        code_eff = (code_i > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_i;
        factor   = PROD_W'(code_eff) + PROD_W'(CODE_OFS);
        prod     = PROD_W'(base_i) * factor;
        amp_o    = (prod > PROD_W'({COL_W{1'b1}})) ? '1 : prod[COL_W-1:0];
    end

    always_comb begin
        assert_zero_base_R6: assert (base_i != '0 || amp_o == '0);
        assert_invalid_fold_R7: assert (code_i <= CODE_W'(MAX_CODE) || base_i == '0 || amp_o != '0);
    end
endmodule

// File: rtl/pframe_gen.sv
`timescale 1ns/1ps
// pframe_gen: picture frame border generator top.
// Replaces pixels outside the programmed window with a per-channel border
// colour and reports the overlay priority while inserting. Assumes one pixel
// per clock and sync strobes one cycle wide. One cycle of latency.
module pframe_gen
    import pframe_pkg::*;
#(
    parameter int HPOS_W = HPOS_W_D,
    parameter int LINE_W = LINE_W_D,
    parameter int VREG_W = VREG_W_D,
    parameter int VOFS   = VOFS_D,
    parameter int COL_W  = COL_W_D,
    parameter int CODE_W = CODE_W_D,
    parameter int ID_W   = ID_W_D,
    parameter int NCH    = NCH_D,
    parameter int DATA_W = DATA_W_D,
    parameter int ADDR_W = ADDR_W_D
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hsync_i,
    input  logic                  vsync_i,
    input  logic [NCH*COL_W-1:0]  pix_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    output logic [NCH*COL_W-1:0]  pix_o,
    output logic [ID_W-1:0]       prio_o
);
    logic [HPOS_W-1:0]          hbeg, hend;
    logic [VREG_W-1:0]          vbeg, vend;
    logic [NCH-1:0][COL_W-1:0]  base;
    logic [NCH-1:0][CODE_W-1:0] code;
    logic [ID_W-1:0]            id;
    logic                       en;
    logic                       border;
    logic [NCH*COL_W-1:0]       fill;

    pframe_regs #(
        .HPOS_W(HPOS_W), .VREG_W(VREG_W), .COL_W(COL_W), .CODE_W(CODE_W),
        .ID_W(ID_W), .NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .hbeg_o(hbeg), .hend_o(hend), .vbeg_o(vbeg), .vend_o(vend),
        .base_o(base), .code_o(code), .id_o(id), .en_o(en)
    );

    pframe_raster #(
        .HPOS_W(HPOS_W), .LINE_W(LINE_W), .VREG_W(VREG_W), .VOFS(VOFS)
    ) u_raster (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
        .hbeg_i(hbeg), .hend_i(hend), .vbeg_i(vbeg), .vend_i(vend),
        .border_o(border)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_amp
        pframe_amp #(.COL_W(COL_W), .CODE_W(CODE_W)) u_amp (
            .base_i(base[c]), .code_i(code[c]),
            .amp_o(fill[c*COL_W +: COL_W])
        );
    end

    // Output stage: insert border colour and priority, or pass video through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_o  <= '0;
            prio_o <= '0;
        end else if (en && border) begin
            pix_o  <= fill;
            prio_o <= id;
        end else begin
            pix_o  <= pix_i;
            prio_o <= '0;
        end
    end

    assert_pass_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (prio_o == '0 && pix_o == $past(pix_i)));
    assert_full_line_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hbeg == '1) |=> (prio_o == $past(id)));
    assert_prio_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_o != '0) |-> $past(en));
    assert_off_horiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hbeg == '0 && vbeg == '0) |=> (pix_o == $past(pix_i)));
endmodule

// File: tb/pframe_gen_test.sv
`timescale 1ns/1ps
module pframe_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync_i = 1'b0, vsync_i = 1'b0;
    logic [23:0] pix_i = '0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [23:0] pix_o;
    logic [2:0]  prio_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pframe_gen uut (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
        .pix_i(pix_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .pix_o(pix_o), .prio_o(prio_o)
    );

    always #2.5 clk = ~clk;

    // {code[3:0], base[7:0], expected amplitude[7:0]} for channel 0
    localparam logic [19:0] AMP_VEC [10] = '{
        {4'd0,  8'd10,  8'd40},
        {4'd8,  8'd10,  8'd120},
        {4'd13, 8'd15,  8'd255},
        {4'd14, 8'd10,  8'd170},
        {4'd15, 8'd10,  8'd170},
        {4'd13, 8'd16,  8'd255},
        {4'd5,  8'd0,   8'd0},
        {4'd2,  8'd255, 8'd255},
        {4'd9,  8'd19,  8'd247},
        {4'd1,  8'd51,  8'd255}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(posedge clk); #1;
        wr_en_i = 1'b0;
    endtask

    task automatic step(input logic hs, input logic vs, input logic [23:0] p);
        @(negedge clk);
        hsync_i = hs; vsync_i = vs; pix_i = p;
        @(posedge clk); #1;
        hsync_i = 1'b0; vsync_i = 1'b0;
    endtask

    localparam logic [23:0] VID    = 24'h123456;
    localparam logic [23:0] BORDER = 24'h005028; // ch2 0, ch1 80, ch0 40

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pix", pix_o, 0);
        chk("R1 reset prio", prio_o, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1: defaults pass video through with priority 0
        step(1'b1, 1'b1, 24'hABCDEF);
        chk("R1 default pass", pix_o, 24'hABCDEF);
        chk("R1 default prio", prio_o, 0);

        // R2: output holds until the next edge
        @(negedge clk); pix_i = 24'h111111; #1;
        chk("R2 hold before edge", pix_o, 24'hABCDEF);
        @(posedge clk); #1;
        chk("R2 one cycle later", pix_o, 24'h111111);

        // R4 full line, R6/R7 amplitude table walk, R1 default id 7
        wr(3'd0, 16'h07FF);
        step(1'b0, 1'b0, VID);
        chk("R1 default id", prio_o, 7);
        chk("R1 default base", pix_o, 0);
        for (int i = 0; i < 10; i++) begin
            wr(3'd4, {4'd0, AMP_VEC[i][19:16], AMP_VEC[i][15:8]});
            step(1'b0, 1'b0, VID);
            chk("R6/R7 amplitude", pix_o[7:0], AMP_VEC[i][7:0]);
            chk("R4 full line prio", prio_o, 7);
        end

        // R9: channel 1 register at address 5, channel 0 back to 40
        wr(3'd5, {4'd0, 4'd0, 8'd20});
        wr(3'd4, {4'd0, 4'd0, 8'd10});
        step(1'b0, 1'b0, VID);
        chk("R9 channel layout", pix_o, BORDER);

        // R3: window 10..20
        wr(3'd0, 16'd10);
        wr(3'd1, 16'd20);
        step(1'b1, 1'b0, VID);
        for (int k = 0; k < 23; k++) begin
            step(1'b0, 1'b0, VID);
            chk("R3 horizontal window", pix_o,
                ((k < 10) || (k > 20)) ? BORDER : VID);
            chk("R8 window prio", prio_o, ((k < 10) || (k > 20)) ? 7 : 0);
        end

        // R4: begin 0 disables horizontal border
        wr(3'd0, 16'd0);
        step(1'b1, 1'b0, VID);
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b0, VID);
            chk("R4 horizontal off", pix_o, VID);
        end

        // R5: vertical window lines 129..130
        wr(3'd2, 16'd1);
        wr(3'd3, 16'd2);
        step(1'b1, 1'b1, VID);
        for (int m = 1; m <= 131; m++) begin
            step(1'b1, 1'b0, VID);
            if (m >= 128) begin
                step(1'b0, 1'b0, VID);
                chk("R5 vertical window", pix_o,
                    ((m < 129) || (m > 130)) ? BORDER : VID);
            end
        end
        wr(3'd2, 16'd0);
        step(1'b0, 1'b0, VID);
        chk("R5 vertical off", pix_o, VID);

        // R8: enable clear on a full-line border
        wr(3'd0, 16'h07FF);
        wr(3'd7, 16'h0005);
        step(1'b0, 1'b0, VID);
        chk("R8 disabled pass", pix_o, VID);
        chk("R8 disabled prio", prio_o, 0);
        wr(3'd7, 16'h0105);
        step(1'b0, 1'b0, VID);
        chk("R8 enabled border", pix_o, BORDER);
        chk("R8 enabled id", prio_o, 5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule